// File: doc/BRIEF.md
# Tagged Capability Memory Guard

This block is a small word-addressed store of 128-bit words. Each word carries a one-bit type marker that says whether it holds a capability or ordinary data. Each word also carries a check bit whose parity sense depends on that marker. The block sits between a core's request port and the storage. Every access is typed. Data loads and stores may touch only data words, and capability loads and stores may touch only capability words. A data access therefore can never read the bits of a capability or overwrite them. A mismatched access is refused with a fault code, and the stored word and its marker stay exactly as they were.

Two privileged conversion requests flip a word's marker in place. One turns data into a capability and the other turns a capability back into data. Each conversion keeps the contents and re-encodes the check bit in the new sense. The check bit uses even parity for data words and odd parity for capability words. A load or conversion of a word whose check bit does not fit the sense of its marker reports a parity fault. Every accepted request gets exactly one response, one cycle after it is accepted.

Top module: `tagmem_guard`

## Requirements
- R1: While reset is held, req_ready_o and rsp_valid_o are 0. Within three cycles after release, req_ready_o is 1. Every word then reads back as a data word with zero contents.
- R2: A request is accepted in a cycle where req_valid_i and req_ready_o are both 1. rsp_valid_o is 1 in the next cycle exactly once for it. Without an accepted request, rsp_valid_o is 0.
- R3: A data load (req_op_i = 2'b00, req_cvt_i = 0) of a data word returns its contents with rsp_fault_o = 2'b00 (no fault).
- R4: A data store (req_op_i = 2'b01) to a data word replaces its contents and keeps it a data word.
- R5: A data load or data store on a capability word returns rsp_fault_o = 2'b01 (type mismatch), and the word keeps its contents and its marker.
- R6: A capability load (2'b10) or capability store (2'b11) on a data word returns rsp_fault_o = 2'b01, and the word is left unchanged.
- R7: Capability loads and stores on a capability word succeed, returning or replacing its contents.
- R8: With priv_i = 1, a conversion (req_cvt_i = 1) with req_dir_i = 0 turns a data word into a capability, and one with req_dir_i = 1 turns a capability into data. The contents are kept in both cases. A conversion whose source word has the other marker faults with 2'b01 and changes nothing. req_op_i is ignored while req_cvt_i is 1.
- R9: A conversion with priv_i = 0 returns rsp_fault_o = 2'b11 (privilege) and changes nothing.
- R10: Data words hold even parity and capability words hold odd parity. A load or conversion of a word whose check bit is wrong for its marker returns rsp_fault_o = 2'b10 and changes nothing. par_flip_i = 1 on a successful store writes the check bit inverted. A later store writes it correctly again, because stores do not check the old word.
- R11: When several faults apply, privilege is reported before type mismatch, and type mismatch before parity.
- R12: rsp_data_o is zero for every faulting response and for every store or conversion response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_op_i | input | 2 | Access kind: 00 data load, 01 data store, 10 capability load, 11 capability store |
| req_cvt_i | input | 1 | Request is a marker conversion |
| req_dir_i | input | 1 | Conversion direction: 0 data to capability, 1 capability to data |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DATA_W | Store data |
| priv_i | input | 1 | Requester is privileged |
| par_flip_i | input | 1 | Store writes an inverted check bit |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | 2 | 00 none, 01 type mismatch, 10 parity, 11 privilege |
| rsp_data_o | output | DATA_W | Load data, zero otherwise |

## Verification
The assertions check the following on every cycle. Each accepted request gets one response in the following cycle, and no response appears without one. Faulting responses carry zero data. A typed access to a word with the other marker reports a type mismatch. An unprivileged conversion reports a privilege fault and leaves the word's marker alone. A wrongly encoded check bit reports a parity fault. Only the bench's scenarios show the following: that stored contents survive refused accesses, that a conversion keeps the contents, that a corrupted word recovers after a rewrite, and that the fault priority holds across sequences of dependent requests.

// File: rtl/cmg_pkg.sv
package cmg_pkg;

  typedef enum logic [1:0] {
    OP_DLOAD  = 2'b00,
    OP_DSTORE = 2'b01,
    OP_CLOAD  = 2'b10,
    OP_CSTORE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_TYPE = 2'b01,
    FLT_PAR  = 2'b10,
    FLT_PRIV = 2'b11
  } fault_e;

  // marker value: 0 = data word (even parity), 1 = capability word (odd parity)
  localparam logic MARK_DATA = 1'b0;
  localparam logic MARK_CAP  = 1'b1;

  // check bit for a word given the xor-fold of its contents and its marker
  function automatic logic check_bit(input logic fold, input logic mark);
    return fold ^ mark;
  endfunction

endpackage

// File: rtl/cmg_store.sv
module cmg_store #(
  parameter int DATA_W = 128,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_mark_o,
  output logic              rd_chk_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_mark_i,
  input  logic              wr_chk_i,
  output logic [DEPTH-1:0]  mark_vec_o
);

  logic [DATA_W-1:0] word_q [DEPTH];
  logic [DEPTH-1:0]  mark_q;
  logic [DEPTH-1:0]  chk_q;
  logic [DEPTH-1:0]  wsel;

  // per-word write select
  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    assign wsel[i] = wr_en_i && (wr_addr_i == AW'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        word_q[i] <= '0;
      end
      mark_q <= '0;
      chk_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wsel[i]) begin
          word_q[i] <= wr_data_i;
          mark_q[i] <= wr_mark_i;
          chk_q[i]  <= wr_chk_i;
        end
      end
    end
  end

  assign rd_data_o  = word_q[rd_addr_i];
  assign rd_mark_o  = mark_q[rd_addr_i];
  assign rd_chk_o   = chk_q[rd_addr_i];
  assign mark_vec_o = mark_q;

endmodule

// File: rtl/cmg_decide.sv
module cmg_decide
  import cmg_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              go_i,
  input  op_e               op_i,
  input  logic              cvt_i,
  input  logic              dir_i,
  input  logic              priv_i,
  input  logic              flip_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_mark_i,
  input  logic              rd_chk_i,
  output fault_e            fault_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_mark_o,
  output logic              wr_chk_o
);

  logic need_mark;
  logic reads_old;
  logic writes;
  logic chk_ok;

  always_comb begin
    need_mark = cvt_i ? dir_i : op_i[1];
    reads_old = cvt_i || !op_i[0];
    writes    = cvt_i || op_i[0];
    chk_ok    = (rd_chk_i == check_bit(^rd_data_i, rd_mark_i));

    if (cvt_i && !priv_i) begin
      fault_o = FLT_PRIV;
    end else if (rd_mark_i != need_mark) begin
      fault_o = FLT_TYPE;
    end else if (reads_old && !chk_ok) begin
      fault_o = FLT_PAR;
    end else begin
      fault_o = FLT_NONE;
    end

    wr_en_o   = go_i && writes && (fault_o == FLT_NONE);
    wr_data_o = cvt_i ? rd_data_i : wdata_i;
    wr_mark_o = cvt_i ? ~rd_mark_i : rd_mark_i;
    wr_chk_o  = check_bit(^wr_data_o, wr_mark_o) ^ (flip_i && !cvt_i);

    ld_data_o = (!writes && fault_o == FLT_NONE) ? rd_data_i : '0;
  end

endmodule

// File: rtl/tagmem_guard.sv
module tagmem_guard
  import cmg_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic              req_cvt_i,
  input  logic              req_dir_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              priv_i,
  input  logic              par_flip_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_fault_o,
  output logic [DATA_W-1:0] rsp_data_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic              accept;
  logic [DATA_W-1:0] rd_data;
  logic              rd_mark, rd_chk;
  logic [DEPTH-1:0]  mark_vec;
  fault_e            fault;
  logic [DATA_W-1:0] ld_data;
  logic              wr_en, wr_mark, wr_chk;
  logic [DATA_W-1:0] wr_data;

  assign req_ready_o = rst_sync_q;
  assign accept      = req_valid_i && req_ready_o;

  cmg_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .rd_addr_i  (req_addr_i),
    .rd_data_o  (rd_data),
    .rd_mark_o  (rd_mark),
    .rd_chk_o   (rd_chk),
    .wr_en_i    (wr_en),
    .wr_addr_i  (req_addr_i),
    .wr_data_i  (wr_data),
    .wr_mark_i  (wr_mark),
    .wr_chk_i   (wr_chk),
    .mark_vec_o (mark_vec)
  );

  cmg_decide #(.DATA_W(DATA_W)) u_decide (
    .go_i      (accept),
    .op_i      (op_e'(req_op_i)),
    .cvt_i     (req_cvt_i),
    .dir_i     (req_dir_i),
    .priv_i    (priv_i),
    .flip_i    (par_flip_i),
    .wdata_i   (req_wdata_i),
    .rd_data_i (rd_data),
    .rd_mark_i (rd_mark),
    .rd_chk_i  (rd_chk),
    .fault_o   (fault),
    .ld_data_o (ld_data),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .wr_mark_o (wr_mark),
    .wr_chk_o  (wr_chk)
  );

  // response stage: next-state and register processes
  logic              rsp_valid_d, rsp_valid_q;
  logic [1:0]        rsp_fault_d, rsp_fault_q;
  logic [DATA_W-1:0] rsp_data_d,  rsp_data_q;

  always_comb begin
    rsp_valid_d = accept;
    rsp_fault_d = rsp_fault_q;
    rsp_data_d  = rsp_data_q;
    if (accept) begin
      rsp_fault_d = fault;
      rsp_data_d  = ld_data;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= '0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_fault_q <= rsp_fault_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_fault_o = rsp_fault_q;
  assign rsp_data_o  = rsp_data_q;

endmodule

// File: rtl/cmg_sva.sv
module cmg_sva #(
  parameter int DATA_W = 128,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc,
  input logic [1:0]        op,
  input logic              cvt,
  input logic              dir,
  input logic              priv,
  input logic [AW-1:0]     addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_mark,
  input logic              rd_chk,
  input logic [DEPTH-1:0]  mark_vec,
  input logic              rsp_valid,
  input logic [1:0]        rsp_fault,
  input logic [DATA_W-1:0] rsp_data
);

  assert_rsp_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);

  assert_fault_zero_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> rsp_data == '0);

  assert_data_op_on_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cvt && !op[1] && rd_mark) |=> rsp_fault == 2'b01);

  assert_cap_op_on_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cvt && op[1] && !rd_mark) |=> rsp_fault == 2'b01);

  assert_unpriv_convert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cvt && !priv) |=> (rsp_fault == 2'b11 && mark_vec[$past(addr)] == $past(rd_mark)));

  assert_bad_check_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cvt && !op[0] && (rd_mark == op[1]) && (rd_chk != ((^rd_data) ^ rd_mark)))
      |=> rsp_fault == 2'b10);

  assert_good_convert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cvt && priv && (rd_mark == dir) && (rd_chk == ((^rd_data) ^ rd_mark)))
      |=> (rsp_fault == 2'b00 && mark_vec[$past(addr)] == !$past(rd_mark)));

endmodule

bind tagmem_guard cmg_sva #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_sva (
  .clk       (clk_i),
  .rst_n     (rst_sync_q),
  .acc       (accept),
  .op        (req_op_i),
  .cvt       (req_cvt_i),
  .dir       (req_dir_i),
  .priv      (priv_i),
  .addr      (req_addr_i),
  .rd_data   (rd_data),
  .rd_mark   (rd_mark),
  .rd_chk    (rd_chk),
  .mark_vec  (mark_vec),
  .rsp_valid (rsp_valid_o),
  .rsp_fault (rsp_fault_o),
  .rsp_data  (rsp_data_o)
);

// File: tb/tagmem_guard_tb_top.sv
module tagmem_guard_tb_top;

  localparam int DW = 128;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic req_cvt = 1'b0;
  logic req_dir = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic priv = 1'b0;
  logic par_flip = 1'b0;
  logic rsp_valid;
  logic [1:0] rsp_fault;
  logic [DW-1:0] rsp_data;

  always #5 clk = ~clk;

  tagmem_guard #(.DATA_W(DW), .DEPTH(DEPTH), .AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_cvt_i(req_cvt), .req_dir_i(req_dir), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .priv_i(priv), .par_flip_i(par_flip),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_data_o(rsp_data)
  );

  typedef struct {
    logic [1:0]    fault;
    logic [DW-1:0] data;
    string         req;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state from the requirements
  logic [DW-1:0] m_data [DEPTH];
  bit m_cap [DEPTH];
  bit m_bad [DEPTH];

  task automatic send(input logic [1:0] op, input bit cvt, input bit dir, input int a,
                      input logic [DW-1:0] wd, input bit pv, input bit flip, input string req);
    exp_t e;
    bit need;
    bit rd_old;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_cvt = cvt; req_dir = dir;
    req_addr = AW'(a); req_wdata = wd; priv = pv; par_flip = flip;
    need = cvt ? dir : op[1];
    rd_old = cvt || !op[0];
    e.req = req;
    e.data = '0;
    if (cvt && !pv) e.fault = 2'b11;
    else if (m_cap[a] != need) e.fault = 2'b01;
    else if (rd_old && m_bad[a]) e.fault = 2'b10;
    else begin
      e.fault = 2'b00;
      if (cvt) begin
        m_cap[a] = !m_cap[a];
        m_bad[a] = 1'b0;
      end else if (op[0]) begin
        m_data[a] = wd;
        m_bad[a] = flip;
      end else begin
        e.data = m_data[a];
      end
    end
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares responses in order
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        checks++;
        if (sb_q.size() == 0) begin
          errors++;
          $display("FAIL R2: response without request, actual valid=1 expected 0");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (rsp_fault !== e.fault || rsp_data !== e.data) begin
            errors++;
            $display("FAIL %s: actual fault=%0d data=%h expected fault=%0d data=%h",
                     e.req, rsp_fault, rsp_data, e.fault, e.data);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [DW-1:0] VA = {32'h1111_0001, 32'hA5A5_0002, 32'h0F0F_0003, 32'h8000_0004};
  localparam logic [DW-1:0] VB = {32'hDEAD_BEEF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
  localparam logic [DW-1:0] VC = {4{32'h0000_0001}};
  localparam logic [DW-1:0] VD = {4{32'h7777_7777}};
  localparam logic [DW-1:0] VE = {4{32'h0000_0007}};
  localparam logic [DW-1:0] VF = {4{32'hC0DE_0101}};

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_data[i] = '0; m_cap[i] = 1'b0; m_bad[i] = 1'b0;
    end
    // R1: held reset
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (req_ready !== 1'b0 || rsp_valid !== 1'b0) begin
        errors++;
        $display("FAIL R1: actual ready=%b rsp_valid=%b expected 0 0", req_ready, rsp_valid);
      end
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1: actual ready=%b expected 1", req_ready);
    end

    // R1 / R3: cleared words read as zero data
    send(2'b00, 0, 0, 0,  '0, 0, 0, "R1");
    send(2'b00, 0, 0, 5,  '0, 0, 0, "R1");
    send(2'b00, 0, 0, 15, '0, 0, 0, "R1");
    // R3 / R4
    send(2'b01, 0, 0, 3, VA, 0, 0, "R4");
    send(2'b00, 0, 0, 3, '0, 0, 0, "R3");
    idle(2);
    // R9: unprivileged conversion refused, word intact
    send(2'b00, 1, 0, 3, '0, 0, 0, "R9");
    send(2'b00, 0, 0, 3, '0, 0, 0, "R9");
    // R8 data to capability; R5 data path refused; R7 capability path
    send(2'b01, 1, 0, 3, '0, 1, 0, "R8");
    send(2'b00, 0, 0, 3, '0, 0, 0, "R5");
    send(2'b01, 0, 0, 3, VF, 0, 0, "R5");
    send(2'b10, 0, 0, 3, '0, 0, 0, "R7");
    send(2'b11, 0, 0, 3, VB, 0, 0, "R7");
    send(2'b10, 0, 0, 3, '0, 0, 0, "R7");
    // R6: capability path on a data word
    send(2'b10, 0, 0, 4, '0, 0, 0, "R6");
    send(2'b11, 0, 0, 4, VF, 0, 0, "R6");
    send(2'b00, 0, 0, 4, '0, 0, 0, "R6");
    // R8 wrong-direction conversions
    send(2'b00, 1, 1, 4, '0, 1, 0, "R8");
    send(2'b00, 1, 0, 3, '0, 1, 0, "R8");
    send(2'b00, 1, 1, 3, '0, 1, 0, "R8");
    send(2'b00, 0, 0, 3, '0, 0, 0, "R8");
    // R10: corrupted data word, then rewrite
    send(2'b01, 0, 0, 6, VC, 0, 1, "R10");
    send(2'b00, 0, 0, 6, '0, 0, 0, "R10");
    send(2'b00, 1, 0, 6, '0, 1, 0, "R10");
    send(2'b00, 1, 0, 6, '0, 0, 0, "R11");
    send(2'b01, 0, 0, 6, VD, 0, 0, "R10");
    send(2'b00, 0, 0, 6, '0, 0, 0, "R10");
    // R10 / R11: corrupted capability word
    send(2'b00, 1, 0, 7, '0, 1, 0, "R8");
    send(2'b11, 0, 0, 7, VE, 0, 1, "R10");
    send(2'b10, 0, 0, 7, '0, 0, 0, "R10");
    send(2'b00, 0, 0, 7, '0, 0, 0, "R11");
    send(2'b00, 1, 1, 7, '0, 1, 0, "R10");
    send(2'b11, 0, 0, 7, VF, 0, 0, "R7");
    send(2'b10, 0, 0, 7, '0, 0, 0, "R7");
    idle(1);
    // mixed back-to-back traffic, R12 on store/convert responses
    for (int k = 0; k < 400; k++) begin
      logic [DW-1:0] wd;
      wd = {$urandom, $urandom, $urandom, $urandom};
      send(2'($urandom), ($urandom % 5) == 0, 1'($urandom), int'($urandom % DEPTH), wd,
           1'($urandom), ($urandom % 7) == 0, "R12");
      if ((k % 37) == 0) idle(1);
    end
    idle(4);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R2: actual pending=%0d expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule